// File: doc/BRIEF.md
# Processor Watchdog with Extended Startup Window

This block supervises a processor by watching a toggling input pin and a software kick strobe. After each reset event it first opens a long startup window, which gives a slow boot time to finish. The first kick inside that window switches the block to a shorter routine timeout. If the processor stops kicking for a full period, the fault output goes high. It stays high until the next kick, or until the block is forced back into hold.

All time is measured in ticks of an external prescaled strobe. A 3-bit code sets the startup window and a second select sets the routine period. Each is a binary power-of-two multiple of a base parameter. An arming mode decides how the block relates to the system reset. In dependent mode the block is held while system reset is active. In independent mode it runs as soon as it is enabled and the supply is good, and the system reset has no effect.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `wdo` is 0. All internal state is cleared.
- R2: With `indep_mode` = 0 and `sys_rst_active` = 1, the block is held: `wdo` is 0 from the next clock, and the counter stays cleared.
- R3: With `indep_mode` = 1, `sys_rst_active` is ignored. The block counts and times out exactly as it does when reset is inactive.
- R4: While `enable` = 0 or `supply_ok` = 0, the block is held and `wdo` is 0 from the next clock, whatever the mode.
- R5: On leaving hold, the block spends one clock arming. If `startup_sel` is nonzero, it then opens a startup window of `STARTUP_BASE << (startup_sel-1)` ticks. If that many ticks pass with no kick, `wdo` goes to 1 on the clock that takes the last tick.
- R6: If `startup_sel` = 0, no startup window is opened. The block goes from arming straight into the routine period.
- R7: A kick during the startup window ends it and starts the routine period of `TIMEOUT_BASE << timeout_sel` ticks, counted from zero.
- R8: In the routine period, every kick clears the tick count. When the count reaches the period with no kick, `wdo` goes to 1 on the clock that takes the last tick. A kick in the same clock as a tick takes priority.
- R9: A kick is a rising or a falling transition of `wdi_pin`, which reaches the counter on the third clock edge after it, or a high `sw_kick`, which acts on the next edge.
- R10: While `wdo` is 1, a kick clears it on the next edge and starts a new routine period from zero.
- R11: In dependent mode, asserting and then releasing `sys_rst_active` clears `wdo` and opens the startup window again. So does cycling `enable` or `supply_ok`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Prescaled time-base strobe, one clock wide |
| wdi_pin | input | 1 | Asynchronous watchdog input from the processor |
| sw_kick | input | 1 | Software kick pulse |
| enable | input | 1 | Watchdog enable; low holds the block |
| supply_ok | input | 1 | Supply above threshold and boot complete |
| sys_rst_active | input | 1 | System reset is asserted |
| indep_mode | input | 1 | 0 = dependent on system reset, 1 = independent |
| startup_sel | input | 3 | Startup window code, 0 disables the window |
| timeout_sel | input | TSEL_W | Routine period select |
| wdo | output | 1 | Registered watchdog fault output |

## Verification
The bench builds the block with `STARTUP_BASE` = 6, `TIMEOUT_BASE` = 3 and a 2-bit timeout select. With these values the longest startup window (384 ticks) and every routine period fit into short runs. Each code can therefore be driven all the way to expiry, and the random phase can cross between the startup and routine phases many times. Driving the tick every clock in the directed cases makes the expiry clock exact. The random phase varies the tick density, the arming mode, the hold inputs and the kick sources together.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WD_IDLE    = 2'd0,
    WD_STARTUP = 2'd1,
    WD_NORMAL  = 2'd2,
    WD_FAULT   = 2'd3
  } wd_state_e;
endpackage

// File: rtl/wdi_edge_sync.sv
module wdi_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic edge_det
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= 1'b0;
    else     chain[0] <= pin;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else     chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= chain[STAGES-1];
  end

  assign edge_det = chain[STAGES-1] ^ prev;
endmodule

// File: rtl/wdog_limits.sv
module wdog_limits #(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned STARTUP_BASE = 4688,
  parameter int unsigned TIMEOUT_BASE = 100,
  parameter int unsigned TSEL_W       = 2
) (
  input  logic [2:0]        startup_sel,
  input  logic [TSEL_W-1:0] timeout_sel,
  output logic              startup_en,
  output logic [CNT_W-1:0]  startup_lim,
  output logic [CNT_W-1:0]  timeout_lim
);
  localparam logic [CNT_W-1:0] S_BASE = CNT_W'(STARTUP_BASE);
  localparam logic [CNT_W-1:0] T_BASE = CNT_W'(TIMEOUT_BASE);

  assign startup_en  = |startup_sel;
  assign startup_lim = startup_en ? (S_BASE << (startup_sel - 3'd1)) : S_BASE;
  assign timeout_lim = T_BASE << timeout_sel;
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tick,
  input  logic             kick,
  input  logic             startup_en,
  input  logic [CNT_W-1:0] startup_lim,
  input  logic [CNT_W-1:0] timeout_lim,
  output logic             fault
);
  wd_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cur_lim;
  logic [CNT_W:0]   cnt_inc;
  logic             expire;

  assign cur_lim = (state == WD_STARTUP) ? startup_lim : timeout_lim;
  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign expire  = tick && (cnt_inc >= {1'b0, cur_lim});

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      state <= WD_IDLE;
      cnt   <= '0;
      fault <= 1'b0;
    end else begin
      unique case (state)
        WD_IDLE: begin
          state <= startup_en ? WD_STARTUP : WD_NORMAL;
          cnt   <= '0;
        end
        WD_STARTUP, WD_NORMAL: begin
          if (kick) begin
            state <= WD_NORMAL;
            cnt   <= '0;
          end else if (expire) begin
            state <= WD_FAULT;
            cnt   <= '0;
            fault <= 1'b1;
          end else if (tick) begin
            cnt <= cnt_inc[CNT_W-1:0];
          end
        end
        WD_FAULT: begin
          if (kick) begin
            state <= WD_NORMAL;
            cnt   <= '0;
            fault <= 1'b0;
          end
        end
        default: state <= WD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor #(
  parameter int unsigned CNT_W        = 32,
  parameter int unsigned STARTUP_BASE = 4688,
  parameter int unsigned TIMEOUT_BASE = 100,
  parameter int unsigned TSEL_W       = 2,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wdi_pin,
  input  logic              sw_kick,
  input  logic              enable,
  input  logic              supply_ok,
  input  logic              sys_rst_active,
  input  logic              indep_mode,
  input  logic [2:0]        startup_sel,
  input  logic [TSEL_W-1:0] timeout_sel,
  output logic              wdo
);
  logic             wdi_edge;
  logic             kick;
  logic             armed;
  logic             startup_en;
  logic [CNT_W-1:0] startup_lim;
  logic [CNT_W-1:0] timeout_lim;

  wdi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .pin      (wdi_pin),
    .edge_det (wdi_edge)
  );

  wdog_limits #(
    .CNT_W        (CNT_W),
    .STARTUP_BASE (STARTUP_BASE),
    .TIMEOUT_BASE (TIMEOUT_BASE),
    .TSEL_W       (TSEL_W)
  ) u_limits (
    .startup_sel (startup_sel),
    .timeout_sel (timeout_sel),
    .startup_en  (startup_en),
    .startup_lim (startup_lim),
    .timeout_lim (timeout_lim)
  );

  // Arming: dependent mode additionally waits for system reset release
  assign armed = enable && supply_ok && (indep_mode || !sys_rst_active);
  assign kick  = wdi_edge || sw_kick;

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk         (clk),
    .rst         (rst),
    .hold        (!armed),
    .tick        (tick),
    .kick        (kick),
    .startup_en  (startup_en),
    .startup_lim (startup_lim),
    .timeout_lim (timeout_lim),
    .fault       (wdo)
  );
endmodule

// File: rtl/wdog_supervisor_chk.sv
module wdog_supervisor_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic sw_kick,
  input logic enable,
  input logic supply_ok,
  input logic sys_rst_active,
  input logic indep_mode,
  input logic wdi_edge,
  input logic wdo
);
  assert_rst_clears_R1: assert property (@(posedge clk)
    rst |=> !wdo);

  assert_dep_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!indep_mode && sys_rst_active) |=> !wdo);

  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!enable || !supply_ok) |=> !wdo);

  assert_fault_on_tick_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wdo) |-> $past(tick));

  assert_kick_clears_R10: assert property (@(posedge clk) disable iff (rst)
    (sw_kick || wdi_edge) |=> !wdo);
endmodule

bind wdog_supervisor wdog_supervisor_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .tick           (tick),
  .sw_kick        (sw_kick),
  .enable         (enable),
  .supply_ok      (supply_ok),
  .sys_rst_active (sys_rst_active),
  .indep_mode     (indep_mode),
  .wdi_edge       (wdi_edge),
  .wdo            (wdo)
);

// File: tb/tb_wdog_supervisor.sv
module tb_wdog_supervisor;
  localparam int SB = 6;
  localparam int TB = 3;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wdi_pin = 1'b0, sw_kick = 1'b0;
  logic enable = 1'b0, supply_ok = 1'b0, sys_rst_active = 1'b0, indep_mode = 1'b0;
  logic [2:0] startup_sel = 3'd1;
  logic [TW-1:0] timeout_sel = '0;
  logic wdo;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_s1, m_s2, m_prev, m_wdo;
  int m_st, m_cnt;

  always #2.5 clk = ~clk;

  wdog_supervisor #(.CNT_W(16), .STARTUP_BASE(SB), .TIMEOUT_BASE(TB), .TSEL_W(TW)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wdi_pin(wdi_pin), .sw_kick(sw_kick),
    .enable(enable), .supply_ok(supply_ok), .sys_rst_active(sys_rst_active),
    .indep_mode(indep_mode), .startup_sel(startup_sel), .timeout_sel(timeout_sel), .wdo(wdo));

  function automatic int s_lim(int sel); return SB << (sel - 1); endfunction
  function automatic int t_lim(int sel); return TB << sel; endfunction

  task automatic check(bit ok_bit, string tag, bit act, bit exp_v);
    n_chk++;
    if (!ok_bit) begin
      n_fail++;
      $display("FAIL %s: wdo=%0b expected %0b at %0t", tag, act, exp_v, $time);
    end
  endtask

  task automatic model_edge();
    bit k, hold;
    int lim;
    k = (m_s2 ^ m_prev) | sw_kick;
    hold = !(enable && supply_ok && (indep_mode || !sys_rst_active));
    if (rst || hold) begin
      m_st = 0; m_cnt = 0; m_wdo = 0;
    end else begin
      case (m_st)
        0: begin m_st = (startup_sel != 0) ? 1 : 2; m_cnt = 0; end
        1, 2: begin
          lim = (m_st == 1) ? s_lim(startup_sel) : t_lim(timeout_sel);
          if (k) begin m_st = 2; m_cnt = 0; end
          else if (tick) begin
            if (m_cnt + 1 >= lim) begin m_st = 3; m_cnt = 0; m_wdo = 1; end
            else m_cnt++;
          end
        end
        default: if (k) begin m_st = 2; m_cnt = 0; m_wdo = 0; end
      endcase
    end
    if (rst) begin m_s1 = 0; m_s2 = 0; m_prev = 0; end
    else begin m_prev = m_s2; m_s2 = m_s1; m_s1 = wdi_pin; end
  endtask

  task automatic cyc(string tag, int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(wdo === m_wdo, tag, wdo, m_wdo);
    end
  endtask

  task automatic run_until_fault(string tag, int max_c);
    for (int i = 0; i < max_c && !m_wdo; i++) cyc(tag);
    check(wdo === 1'b1, {tag, " expiry"}, wdo, 1'b1);
  endtask

  task automatic pulse_kick(string tag);
    sw_kick = 1; cyc(tag); sw_kick = 0;
  endtask

  task automatic go_active();
    enable = 1; supply_ok = 1; sys_rst_active = 0;
  endtask

  initial begin
    // R1: reset state
    cyc("R1", 3);
    check(wdo === 1'b0, "R1 reset", wdo, 1'b0);
    rst = 0;
    cyc("R1", 1);

    // R5: startup window expiry with sel=1 (6 ticks)
    indep_mode = 0; startup_sel = 3'd1; timeout_sel = 2'd0; tick = 1;
    go_active();
    run_until_fault("R5", 20);

    // R10: software kick clears fault
    pulse_kick("R10");
    check(wdo === 1'b0, "R10 clear", wdo, 1'b0);
    // R8: routine timeout of 3 ticks
    run_until_fault("R8", 10);

    // R9: pin toggles keep it alive, both edges
    pulse_kick("R9");
    for (int i = 0; i < 12; i++) begin
      wdi_pin = ~wdi_pin; cyc("R9", 2);
    end
    check(wdo === 1'b0, "R9 alive", wdo, 1'b0);
    run_until_fault("R9", 12);
    wdi_pin = ~wdi_pin; cyc("R9 pin clears", 4);

    // R2: dependent mode held by system reset
    sys_rst_active = 1; cyc("R2", 20);
    check(wdo === 1'b0, "R2 held", wdo, 1'b0);
    // R11: release re-arms startup window (sel=2 -> 12 ticks)
    startup_sel = 3'd2; sys_rst_active = 0;
    run_until_fault("R11", 30);

    // R3: independent mode ignores system reset
    indep_mode = 1; sys_rst_active = 1; startup_sel = 3'd3;
    enable = 0; cyc("R4", 2); enable = 1;
    run_until_fault("R3", 40);

    // R4: enable low and supply low hold
    enable = 0; cyc("R4", 5);
    check(wdo === 1'b0, "R4 enable", wdo, 1'b0);
    enable = 1; cyc("R4", 5);
    supply_ok = 0; cyc("R4", 5);
    check(wdo === 1'b0, "R4 supply", wdo, 1'b0);
    supply_ok = 1;

    // R6: no startup window, routine period 12 ticks
    indep_mode = 0; sys_rst_active = 0; startup_sel = 3'd0; timeout_sel = 2'd2;
    enable = 0; cyc("R6"); enable = 1;
    run_until_fault("R6", 20);

    // R7: kick in long startup (sel=7) leads to routine period
    startup_sel = 3'd7; timeout_sel = 2'd1;
    enable = 0; cyc("R7"); enable = 1;
    cyc("R7", 50);
    check(wdo === 1'b0, "R7 in startup", wdo, 1'b0);
    pulse_kick("R7");
    run_until_fault("R7", 12);

    // R8 random: mixed stimulus
    void'($urandom(32'h5eed_1234));
    for (int blk = 0; blk < 40; blk++) begin
      indep_mode     = $urandom_range(0, 1);
      sys_rst_active = ($urandom_range(0, 3) == 0);
      enable         = ($urandom_range(0, 7) != 0);
      supply_ok      = ($urandom_range(0, 7) != 0);
      startup_sel    = 3'($urandom_range(0, 7));
      timeout_sel    = TW'($urandom_range(0, 3));
      for (int c = 0; c < 150; c++) begin
        tick    = ($urandom_range(0, 1) == 1);
        sw_kick = ($urandom_range(0, 59) == 0);
        if ($urandom_range(0, 39) == 0) wdi_pin = ~wdi_pin;
        cyc("R8 random");
      end
    end
    sw_kick = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, actual running expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule